// File: doc/BRIEF.md
# Dual-Mode Video Output Port Mux

This block places a 16-bit internal video word on two 8-bit output ports. In single clock mode both ports carry the word side by side, with port A on the high byte and port B on the low byte. In double clock mode the word is split into bytes on port A alone. A double-rate phase input picks the high byte (phase 0) or the low byte (phase 1). Port B is then free. It can drive an 8-bit general-purpose value held in the control field, or it drives zero.

The block also steers a VBI-active qualifier to one of two pins: the video-active pin or an alternate test-output pin. The pin that does not get the qualifier passes its own normal signal through. An 11-bit control field sets all of these choices. It is sampled on every clock and resets to zero, which selects single clock mode with the qualifier on the video-active pin.

The lane is controlled by a three-state machine:
- `ST_PAR` is single clock mode.
- `ST_HI` and `ST_LO` are the double clock phases.

Its transitions are:
- Enter double (`ST_PAR` to `ST_HI` or `ST_LO`, according to phase).
- Phase toggle (`ST_HI` to `ST_LO`, and back).
- Leave double (`ST_HI` or `ST_LO` back to `ST_PAR`, whenever control bit 9 is low).

Top module: `vid_port_mux`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, all four outputs are zero.
- R2: With control bit 9 at 0, one clock after the inputs, port A equals data bits 15:8 and port B equals data bits 7:0.
- R3: With control bit 9 at 1, one clock after the inputs, port A carries data bits 15:8 when phase was 0 and data bits 7:0 when phase was 1.
- R4: With bit 9 at 1 and bit 8 at 1, one clock later port B equals control bits 7:0.
- R5: With bit 9 at 1 and bit 8 at 0, one clock later port B is zero.
- R6: Bit 8 and control bits 7:0 have no effect on port B in single clock mode, where port B still shows data bits 7:0.
- R7: With control bit 10 at 0, one clock later the video-active pin carries the VBI flag and the test pin carries the normal test input.
- R8: With control bit 10 at 1, one clock later the test pin carries the VBI flag and the video-active pin carries the normal active input.
- R9: A change of mode or phase takes effect on the very next clock. Consecutive cycles may alternate freely between single clock mode, high phase and low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | input | 1 | Double-rate phase: 0 selects high byte, 1 selects low byte |
| data_in | input | 16 | Internal video word |
| vbi_flag | input | 1 | VBI-active qualifier |
| act_in | input | 1 | Normal video-active signal |
| tst_in | input | 1 | Normal test-output signal |
| ctrl | input | 11 | [7:0] port B value, [8] port B enable, [9] double mode, [10] qualifier select |
| port_a | output | 8 | Output port A |
| port_b | output | 8 | Output port B |
| act_pin | output | 1 | Video-active pin |
| tst_pin | output | 1 | Test-output pin |

## Verification
Every result of this block is due exactly one clock after the inputs that produce it. This holds for the port bytes, the port B value and the routed qualifier, and control changes follow the same latency as data. The driver applies each stimulus on a falling edge and queues the expected outputs at once. The monitor pops one entry per falling edge, so each comparison lands half a cycle after the rising edge that registered the result. The reset check looks at the outputs while reset is held with non-zero inputs, and the first queued entry after release covers the post-reset cycle.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

    // Lane state: which byte arrangement the ports present this cycle
    typedef enum logic [1:0] {
        ST_PAR = 2'd0,   // single clock, both ports parallel
        ST_HI  = 2'd1,   // double clock, high byte on port A
        ST_LO  = 2'd2    // double clock, low byte on port A
    } lane_state_t;

endpackage

// File: rtl/vpm_ctrl_reg.sv
module vpm_ctrl_reg #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W+2:0] ctrl_in,
    output logic              dbl_now,
    output logic [BYTE_W-1:0] gpo_val_q,
    output logic              gpo_en_q,
    output logic              qsel_q
);
    localparam int GPO_EN_BIT = BYTE_W;
    localparam int DBL_BIT    = BYTE_W + 1;
    localparam int QSEL_BIT   = BYTE_W + 2;

    // Mode bit goes straight to the lane state machine, which registers it
    assign dbl_now = ctrl_in[DBL_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gpo_val_q <= '0;
            gpo_en_q  <= 1'b0;
            qsel_q    <= 1'b0;
        end else begin
            gpo_val_q <= ctrl_in[BYTE_W-1:0];
            gpo_en_q  <= ctrl_in[GPO_EN_BIT];
            qsel_q    <= ctrl_in[QSEL_BIT];
        end
    end

endmodule

// File: rtl/vpm_lane_fsm.sv
module vpm_lane_fsm
    import vpm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dbl_now,
    input  logic        phase,
    output lane_state_t state_q
);
    lane_state_t state_d;

    // Next state: enter double, phase toggle, or leave double
    always_comb begin
        state_d = ST_PAR;
        unique case (state_q)
            ST_PAR: begin
                if (dbl_now) state_d = phase ? ST_LO : ST_HI;
                else         state_d = ST_PAR;
            end
            ST_HI: begin
                if (!dbl_now)   state_d = ST_PAR;
                else if (phase) state_d = ST_LO;
                else            state_d = ST_HI;
            end
            ST_LO: begin
                if (!dbl_now)    state_d = ST_PAR;
                else if (!phase) state_d = ST_HI;
                else             state_d = ST_LO;
            end
            default: state_d = ST_PAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PAR;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/vpm_byte_lane.sv
module vpm_byte_lane
    import vpm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*BYTE_W-1:0] data_in,
    input  lane_state_t         state_q,
    input  logic                gpo_en_q,
    input  logic [BYTE_W-1:0]   gpo_val_q,
    output logic [BYTE_W-1:0]   port_a,
    output logic [BYTE_W-1:0]   port_b
);
    localparam int NBYTES = 2;
    localparam int WORD_W = NBYTES * BYTE_W;

    logic [WORD_W-1:0] word_q;
    logic [BYTE_W-1:0] byte_q [NBYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= data_in;
    end

    // byte_q[1] is the high byte, byte_q[0] the low byte
    for (genvar i = 0; i < NBYTES; i++) begin : g_slice
        assign byte_q[i] = word_q[i*BYTE_W +: BYTE_W];
    end

    // Output process driven by the lane state
    always_comb begin
        port_a = '0;
        port_b = '0;
        unique case (state_q)
            ST_PAR: begin
                port_a = byte_q[1];
                port_b = byte_q[0];
            end
            ST_HI: begin
                port_a = byte_q[1];
                port_b = gpo_en_q ? gpo_val_q : '0;
            end
            ST_LO: begin
                port_a = byte_q[0];
                port_b = gpo_en_q ? gpo_val_q : '0;
            end
            default: begin
                port_a = '0;
                port_b = '0;
            end
        endcase
    end

endmodule

// File: rtl/vpm_qual_route.sv
module vpm_qual_route (
    input  logic clk,
    input  logic rst_n,
    input  logic vbi_flag,
    input  logic act_in,
    input  logic tst_in,
    input  logic qsel_q,
    output logic act_pin,
    output logic tst_pin
);
    logic vbi_q, act_q, tst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vbi_q <= 1'b0;
            act_q <= 1'b0;
            tst_q <= 1'b0;
        end else begin
            vbi_q <= vbi_flag;
            act_q <= act_in;
            tst_q <= tst_in;
        end
    end

    // The pin not chosen keeps its normal signal
    assign act_pin = qsel_q ? act_q : vbi_q;
    assign tst_pin = qsel_q ? vbi_q : tst_q;

endmodule

// File: rtl/vid_port_mux.sv
module vid_port_mux
    import vpm_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 2 * BYTE_W,
    parameter int CTRL_W = BYTE_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic [WORD_W-1:0] data_in,
    input  logic              vbi_flag,
    input  logic              act_in,
    input  logic              tst_in,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [BYTE_W-1:0] port_a,
    output logic [BYTE_W-1:0] port_b,
    output logic              act_pin,
    output logic              tst_pin
);
    logic              dbl_now;
    logic [BYTE_W-1:0] gpo_val_q;
    logic              gpo_en_q;
    logic              qsel_q;
    lane_state_t       state_q;

    vpm_ctrl_reg #(.BYTE_W(BYTE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_in   (ctrl),
        .dbl_now   (dbl_now),
        .gpo_val_q (gpo_val_q),
        .gpo_en_q  (gpo_en_q),
        .qsel_q    (qsel_q)
    );

    vpm_lane_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .dbl_now (dbl_now),
        .phase   (phase),
        .state_q (state_q)
    );

    vpm_byte_lane #(.BYTE_W(BYTE_W)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_in   (data_in),
        .state_q   (state_q),
        .gpo_en_q  (gpo_en_q),
        .gpo_val_q (gpo_val_q),
        .port_a    (port_a),
        .port_b    (port_b)
    );

    vpm_qual_route u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .vbi_flag (vbi_flag),
        .act_in   (act_in),
        .tst_in   (tst_in),
        .qsel_q   (qsel_q),
        .act_pin  (act_pin),
        .tst_pin  (tst_pin)
    );

endmodule

// File: rtl/vpm_checker.sv
module vpm_checker #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                phase,
    input logic [2*BYTE_W-1:0] data_in,
    input logic                vbi_flag,
    input logic                act_in,
    input logic                tst_in,
    input logic [BYTE_W+2:0]   ctrl,
    input logic [BYTE_W-1:0]   port_a,
    input logic [BYTE_W-1:0]   port_b,
    input logic                act_pin,
    input logic                tst_pin
);
    localparam int EN_B = BYTE_W;
    localparam int DB_B = BYTE_W + 1;
    localparam int QS_B = BYTE_W + 2;

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    always_comb begin
        if (!rst_n) begin
            a_reset_r1: assert (port_a == '0 && port_b == '0 && !act_pin && !tst_pin);
        end
    end

    p_par_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(ctrl[DB_B]) |->
            (port_a == $past(data_in[2*BYTE_W-1:BYTE_W]) && port_b == $past(data_in[BYTE_W-1:0])));

    p_hi_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(ctrl[DB_B]) && !$past(phase)) |-> port_a == $past(data_in[2*BYTE_W-1:BYTE_W]));

    p_lo_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(ctrl[DB_B]) && $past(phase)) |-> port_a == $past(data_in[BYTE_W-1:0]));

    p_gpo_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(ctrl[DB_B]) && $past(ctrl[EN_B])) |-> port_b == $past(ctrl[BYTE_W-1:0]));

    p_idle_b_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(ctrl[DB_B]) && !$past(ctrl[EN_B])) |-> port_b == '0);

    p_qual_act_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(ctrl[QS_B]) |-> (act_pin == $past(vbi_flag) && tst_pin == $past(tst_in)));

    p_qual_tst_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(ctrl[QS_B]) |-> (tst_pin == $past(vbi_flag) && act_pin == $past(act_in)));

endmodule

bind vid_port_mux vpm_checker #(.BYTE_W(BYTE_W)) u_vpm_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .data_in  (data_in),
    .vbi_flag (vbi_flag),
    .act_in   (act_in),
    .tst_in   (tst_in),
    .ctrl     (ctrl),
    .port_a   (port_a),
    .port_b   (port_b),
    .act_pin  (act_pin),
    .tst_pin  (tst_pin)
);

// File: tb/vid_port_mux_bench.sv
`timescale 1ns/1ps
module vid_port_mux_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase = 1'b0;
    logic [15:0] data_in = 16'h0000;
    logic        vbi_flag = 1'b0;
    logic        act_in = 1'b0;
    logic        tst_in = 1'b0;
    logic [10:0] ctrl = 11'h000;
    logic [7:0]  port_a, port_b;
    logic        act_pin, tst_pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] a;
        logic [7:0] b;
        logic       act;
        logic       tst;
        string      req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    vid_port_mux u_vid_port_mux (
        .clk(clk), .rst_n(rst_n), .phase(phase), .data_in(data_in),
        .vbi_flag(vbi_flag), .act_in(act_in), .tst_in(tst_in), .ctrl(ctrl),
        .port_a(port_a), .port_b(port_b), .act_pin(act_pin), .tst_pin(tst_pin)
    );

    // Driver: apply on a falling edge, queue what the next rising edge must produce
    task automatic step(input logic [15:0] d, input logic ph, input logic v,
                        input logic ai, input logic ti, input logic [10:0] c,
                        input string req);
        exp_t e;
        @(negedge clk);
        data_in = d; phase = ph; vbi_flag = v; act_in = ai; tst_in = ti; ctrl = c;
        if (!c[9]) begin
            e.a = d[15:8];
            e.b = d[7:0];
        end else begin
            e.a = ph ? d[7:0] : d[15:8];
            e.b = c[8] ? c[7:0] : 8'h00;
        end
        e.act = c[10] ? ai : v;
        e.tst = c[10] ? v : ti;
        e.req = req;
        #1 sb.push_back(e);
    endtask

    // Monitor: one queued item is due at each falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (port_a !== e.a || port_b !== e.b || act_pin !== e.act || tst_pin !== e.tst) begin
                errors++;
                $display("FAIL %s: a=%h b=%h act=%b tst=%b expected a=%h b=%h act=%b tst=%b",
                         e.req, port_a, port_b, act_pin, tst_pin, e.a, e.b, e.act, e.tst);
            end
        end
    end

    initial begin
        // R1: outputs zero under reset despite busy inputs
        data_in = 16'hA55A; ctrl = 11'h7FF; vbi_flag = 1'b1; act_in = 1'b1; tst_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (port_a !== 8'h00 || port_b !== 8'h00 || act_pin !== 1'b0 || tst_pin !== 1'b0) begin
            errors++;
            $display("FAIL R1: a=%h b=%h act=%b tst=%b expected all zero",
                     port_a, port_b, act_pin, tst_pin);
        end
        data_in = 16'h0000; ctrl = 11'h000; vbi_flag = 1'b0; act_in = 1'b0; tst_in = 1'b0;
        rst_n = 1'b1;
        step(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 11'h000, "R1");

        // R2: single clock parallel words
        step(16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 11'h000, "R2");
        step(16'hFEDC, 1'b1, 1'b0, 1'b1, 1'b1, 11'h000, "R2");
        // R6: port B enable and value ignored in single mode
        step(16'h3C5A, 1'b0, 1'b0, 1'b0, 1'b0, 11'h1AA, "R6");
        step(16'h0F0F, 1'b1, 1'b1, 1'b0, 1'b0, 11'h1FF, "R6");

        // R3: double clock, high then low byte
        step(16'hBEEF, 1'b0, 1'b0, 1'b0, 1'b0, 11'h200, "R3");
        step(16'hBEEF, 1'b1, 1'b0, 1'b0, 1'b0, 11'h200, "R3");
        // R5: port B idles at zero
        step(16'hCAFE, 1'b0, 1'b0, 1'b0, 1'b0, 11'h2C3, "R5");
        step(16'hCAFE, 1'b1, 1'b0, 1'b0, 1'b0, 11'h2FF, "R5");
        // R4: port B general-purpose value
        step(16'h8001, 1'b0, 1'b0, 1'b0, 1'b0, 11'h35A, "R4");
        step(16'h8001, 1'b1, 1'b0, 1'b0, 1'b0, 11'h3A5, "R4");
        step(16'h7E7E, 1'b0, 1'b0, 1'b0, 1'b0, 11'h300, "R4");

        // R7: qualifier on video-active pin
        step(16'h0001, 1'b0, 1'b1, 1'b0, 1'b0, 11'h000, "R7");
        step(16'h0002, 1'b0, 1'b0, 1'b1, 1'b1, 11'h000, "R7");
        step(16'h0003, 1'b1, 1'b1, 1'b1, 1'b0, 11'h200, "R7");
        // R8: qualifier on test pin
        step(16'h0004, 1'b0, 1'b1, 1'b0, 1'b0, 11'h400, "R8");
        step(16'h0005, 1'b0, 1'b0, 1'b1, 1'b1, 11'h400, "R8");
        step(16'h0006, 1'b1, 1'b1, 1'b1, 1'b0, 11'h700, "R8");

        // R9: mode and phase change every cycle
        step(16'hA1B2, 1'b0, 1'b1, 1'b0, 1'b1, 11'h000, "R9");
        step(16'hC3D4, 1'b1, 1'b0, 1'b1, 1'b0, 11'h3F0, "R9");
        step(16'hE5F6, 1'b0, 1'b1, 1'b0, 1'b0, 11'h20F, "R9");
        step(16'h0718, 1'b1, 1'b0, 1'b0, 1'b1, 11'h500, "R9");
        step(16'h293A, 1'b1, 1'b1, 1'b1, 1'b1, 11'h755, "R9");
        step(16'h4B5C, 1'b0, 1'b0, 1'b0, 1'b0, 11'h000, "R9");
        for (int i = 0; i < 16; i++) begin
            step(16'(i * 16'h1357 + 16'h0101), 1'(i), 1'(i >> 1), 1'(i >> 2), 1'(i >> 3),
                 11'((i * 11'h0A7) ^ 11'h155), "R9");
        end

        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule